// File: doc/BRIEF.md
# Ultrasonic Ranger Serial Responder

This block stands in for the sensor end of a one-byte command protocol carried over an asynchronous serial line. A host controller sends a single opcode byte. The block answers with a short reply built from two parallel inputs: a 16-bit distance value and an 8-bit temperature value. Its purpose is to give a host-side driver a realistic partner in simulation. It does no measurement of its own.

The receive path has a two-flop synchroniser and a receive state machine. That machine steps through `RX_IDLE`, `RX_START`, `RX_DATA` and `RX_STOP`. It leaves `RX_IDLE` on a falling edge of the line. In `RX_START` it confirms the start bit at mid-period and returns to `RX_IDLE` if the line is high again. In `RX_DATA` it takes eight samples one bit period apart. In `RX_STOP` it passes the byte on only if the stop sample is high.

The reply sequencer steps through `SQ_IDLE`, `SQ_LAUNCH`, `SQ_WAIT` and `SQ_GAP`:
- `SQ_IDLE` moves to `SQ_LAUNCH` when it accepts a known opcode, and captures the reply payload at that moment.
- `SQ_LAUNCH` always moves to `SQ_WAIT` and hands one byte to the transmitter.
- `SQ_WAIT` moves back to `SQ_IDLE` when the transmitter finishes the last byte, or to `SQ_GAP` when it finishes a byte and more remain.
- `SQ_GAP` moves to `SQ_LAUNCH` once the idle gap has elapsed.

The transmitter walks through `TX_IDLE`, `TX_START`, `TX_DATA` and `TX_STOP`.

Top module: `rngr_responder`

## Requirements
- R1: The received byte 0x55 produces a reply of exactly two frames. The first carries distance bits [15:8] and the second carries bits [7:0].
- R2: The received byte 0x50 produces a reply of exactly one frame, which carries the 8-bit temperature value.
- R3: Any other received byte produces no frame on `tx_line` and no `cmd_seen` pulse. This includes the neighbouring codes 0x54 and 0x56.
- R4: Every transmitted frame is one low start bit, then eight data bits LSB first, then one high stop bit. Each bit lasts `BIT_CYCLES` clocks, and the line idles high.
- R5: The receiver takes the line through a two-flop synchroniser and samples each bit at mid-period. A frame whose stop bit samples low is discarded and causes no reply.
- R6: `cmd_seen` is a pulse exactly one clock wide, given once for each accepted command and never for a rejected byte.
- R7: The whole distance value is captured when a command is accepted. Both reply bytes come from that capture, even if `dist_in` changes during the reply.
- R8: `busy` is high from acceptance until the last stop bit of the reply ends. A command that completes reception while `busy` is high is dropped.
- R9: Between the two frames of a distance reply, the line stays idle high for at least `GAP_CYCLES` clocks. The gap is never shorter than one bit period.
- R10: After reset, `tx_line` is high and both `busy` and `cmd_seen` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Serial command input, asynchronous to clk |
| tx_line | output | 1 | Serial reply output, idles high |
| dist_in | input | 16 | Current distance value |
| temp_in | input | 8 | Current temperature value |
| busy | output | 1 | High while a reply is in progress |
| cmd_seen | output | 1 | One-cycle pulse when a command is accepted |

## Verification
A fault in the receive state machine shows up within one frame time. Either no reply appears, or a reply appears for the wrong opcode, or a reply follows a frame with a bad stop bit. A fault in the sequencer's byte count or payload register shows up as a wrong number of reply frames or bytes in the wrong order, observable at the second frame's data bits. Faults in the gap counter or the busy flag are measured in clock cycles between the two frames, and by whether a command sent during a reply leaks into a later frame.

// File: rtl/rngr_pkg.sv
package rngr_pkg;

    localparam logic [7:0] OPC_RANGE = 8'h55;
    localparam logic [7:0] OPC_TEMP  = 8'h50;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_GAP
    } sq_state_t;

endpackage

// File: rtl/rngr_uart_rx.sv
module rngr_uart_rx
    import rngr_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_async,
    output logic [7:0] rx_byte,
    output logic       rx_valid
);

    localparam int CW      = $clog2(BIT_CYCLES + 1);
    localparam int FULL_M1 = BIT_CYCLES - 1;
    localparam int HALF_M1 = BIT_CYCLES / 2 - 1;

    logic          sync_a, sync_b, sync_c;
    logic          line_fall;
    rx_state_t     st_q, st_d;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          at_full, at_half;

    // two-flop synchroniser plus one history stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_a <= 1'b1;
            sync_b <= 1'b1;
            sync_c <= 1'b1;
        end else begin
            sync_a <= rx_async;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    assign line_fall = sync_c & ~sync_b;
    assign at_full   = (cnt == CW'(FULL_M1));
    assign at_half   = (cnt == CW'(HALF_M1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE:  if (line_fall) st_d = RX_START;
            RX_START: if (at_half)   st_d = sync_b ? RX_IDLE : RX_DATA;
            RX_DATA:  if (at_full && bit_idx == 3'd7) st_d = RX_STOP;
            RX_STOP:  if (at_full)   st_d = RX_IDLE;
            default:                 st_d = RX_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            rx_byte  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (st_q == RX_IDLE || st_d != st_q || at_full) cnt <= '0;
            else                                            cnt <= cnt + 1'b1;
            if (st_q == RX_START) bit_idx <= '0;
            if (st_q == RX_DATA && at_full) begin
                shreg   <= {sync_b, shreg[7:1]};
                bit_idx <= bit_idx + 1'b1;
            end
            if (st_q == RX_STOP && at_full && sync_b) begin
                rx_byte  <= shreg;
                rx_valid <= 1'b1;
            end
        end
    end

    // R5: a received byte is reported for exactly one cycle
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5: a byte is only reported as the stop state ends
    p_valid_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(st_q) == RX_STOP);

endmodule

// File: rtl/rngr_uart_tx.sv
module rngr_uart_tx
    import rngr_pkg::*;
#(
    parameter int BIT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_go,
    input  logic [7:0] tx_data,
    output logic       tx_line,
    output logic       tx_done
);

    localparam int CW      = $clog2(BIT_CYCLES + 1);
    localparam int FULL_M1 = BIT_CYCLES - 1;

    tx_state_t     st_q, st_d;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          at_full;

    assign at_full = (cnt == CW'(FULL_M1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TX_IDLE:  if (tx_go)   st_d = TX_START;
            TX_START: if (at_full) st_d = TX_DATA;
            TX_DATA:  if (at_full && bit_idx == 3'd7) st_d = TX_STOP;
            TX_STOP:  if (at_full) st_d = TX_IDLE;
            default:               st_d = TX_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (st_q == TX_IDLE || at_full) cnt <= '0;
            else                            cnt <= cnt + 1'b1;
            if (st_q == TX_IDLE && tx_go) begin
                shreg   <= tx_data;
                bit_idx <= '0;
            end
            if (st_q == TX_DATA && at_full) begin
                shreg   <= {1'b1, shreg[7:1]};
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_line = 1'b1;
        tx_done = 1'b0;
        unique case (st_q)
            TX_IDLE:  tx_line = 1'b1;
            TX_START: tx_line = 1'b0;
            TX_DATA:  tx_line = shreg[0];
            TX_STOP: begin
                tx_line = 1'b1;
                tx_done = at_full;
            end
            default:  tx_line = 1'b1;
        endcase
    end

    // R4: a new frame is only requested while the transmitter is idle
    p_go_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> st_q == TX_IDLE);

    // R4: completion is a single-cycle event
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

endmodule

// File: rtl/rngr_reply_seq.sv
module rngr_reply_seq
    import rngr_pkg::*;
#(
    parameter int GAP_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  rx_byte,
    input  logic        rx_valid,
    input  logic [15:0] dist_in,
    input  logic [7:0]  temp_in,
    input  logic        tx_done,
    output logic        tx_go,
    output logic [7:0]  tx_data,
    output logic        busy,
    output logic        cmd_seen
);

    localparam int GW     = $clog2(GAP_CYCLES + 1);
    localparam int GAP_M1 = GAP_CYCLES - 1;

    sq_state_t     st_q, st_d;
    logic [15:0]   payload;
    logic [1:0]    left;
    logic [GW-1:0] gcnt;
    logic          is_range, is_temp, accept;

    assign is_range = (rx_byte == OPC_RANGE);
    assign is_temp  = (rx_byte == OPC_TEMP);
    assign accept   = (st_q == SQ_IDLE) && rx_valid && (is_range || is_temp);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:   if (accept) st_d = SQ_LAUNCH;
            SQ_LAUNCH: st_d = SQ_WAIT;
            SQ_WAIT:   if (tx_done) st_d = (left == 2'd1) ? SQ_IDLE : SQ_GAP;
            SQ_GAP:    if (gcnt == GW'(GAP_M1)) st_d = SQ_LAUNCH;
            default:   st_d = SQ_IDLE;
        endcase
    end

    // outputs and payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            payload  <= '0;
            left     <= '0;
            gcnt     <= '0;
            cmd_seen <= 1'b0;
        end else begin
            cmd_seen <= accept;
            if (accept) begin
                payload <= is_range ? dist_in : {temp_in, 8'h00};
                left    <= is_range ? 2'd2 : 2'd1;
            end
            if (st_q == SQ_WAIT && tx_done) begin
                payload <= {payload[7:0], 8'h00};
                left    <= left - 1'b1;
            end
            if (st_q == SQ_GAP) gcnt <= gcnt + 1'b1;
            else                gcnt <= '0;
        end
    end

    assign tx_go   = (st_q == SQ_LAUNCH);
    assign tx_data = payload[15:8];
    assign busy    = (st_q != SQ_IDLE);

    // R6: a command-seen pulse follows a received byte
    p_seen_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |-> $past(rx_valid));

    // R6: the command-seen pulse is one cycle wide
    p_seen_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_seen |=> !cmd_seen);

    // R8: busy only drops after the transmitter reports the final frame
    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx_done));

endmodule

// File: rtl/rngr_responder.sv
module rngr_responder
    import rngr_pkg::*;
#(
    parameter int BIT_CYCLES = 16,
    parameter int GAP_CYCLES = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_line,
    output logic        tx_line,
    input  logic [15:0] dist_in,
    input  logic [7:0]  temp_in,
    output logic        busy,
    output logic        cmd_seen
);

    localparam int GAP_EFF = (GAP_CYCLES < BIT_CYCLES) ? BIT_CYCLES : GAP_CYCLES;

    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       tx_go;
    logic [7:0] tx_data;
    logic       tx_done;

    rngr_uart_rx #(.BIT_CYCLES(BIT_CYCLES)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_async (rx_line),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid)
    );

    rngr_reply_seq #(.GAP_CYCLES(GAP_EFF)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .dist_in  (dist_in),
        .temp_in  (temp_in),
        .tx_done  (tx_done),
        .tx_go    (tx_go),
        .tx_data  (tx_data),
        .busy     (busy),
        .cmd_seen (cmd_seen)
    );

    rngr_uart_tx #(.BIT_CYCLES(BIT_CYCLES)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_go   (tx_go),
        .tx_data (tx_data),
        .tx_line (tx_line),
        .tx_done (tx_done)
    );

    // R4: each frame is launched from an idle-high line
    p_launch_from_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> tx_line);

    // R8: a launch only happens while the responder reports busy
    p_launch_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_go |-> busy);

endmodule

// File: tb/tb_rngr_responder.sv
module tb_rngr_responder;

    localparam int BIT   = 16;
    localparam int GAP   = 20;
    localparam int QUIET = 32 * BIT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        tx_line;
    logic [15:0] dist_in = '0;
    logic [7:0]  temp_in = '0;
    logic        busy;
    logic        cmd_seen;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int seen_cnt  = 0;
    int seen_long = 0;
    logic seen_q = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    rngr_responder #(.BIT_CYCLES(BIT), .GAP_CYCLES(GAP)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_line  (rx_line),
        .tx_line  (tx_line),
        .dist_in  (dist_in),
        .temp_in  (temp_in),
        .busy     (busy),
        .cmd_seen (cmd_seen)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        seen_q <= cmd_seen;
        if (rst_n && cmd_seen) seen_cnt <= seen_cnt + 1;
        if (rst_n && cmd_seen && seen_q) seen_long <= seen_long + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit bad_stop);
        @(negedge clk);
        rx_line = 1'b0;
        wait_neg(BIT);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            wait_neg(BIT);
        end
        rx_line = bad_stop ? 1'b0 : 1'b1;
        wait_neg(BIT);
        rx_line = 1'b1;
        if (bad_stop) wait_neg(2 * BIT);
    endtask

    task automatic get_byte(output logic [7:0] b, output bit ok,
                            output int t_start, output int t_stop);
        bit found = 0;
        ok = 1;
        b = '0;
        t_start = 0;
        t_stop = 0;
        for (int i = 0; i < 40 * BIT && !found; i++) begin
            @(negedge clk);
            if (tx_line == 1'b0) found = 1;
        end
        if (!found) begin
            ok = 0;
            return;
        end
        t_start = cyc;
        wait_neg(BIT / 2);
        if (tx_line != 1'b0) ok = 0;
        for (int i = 0; i < 8; i++) begin
            wait_neg(BIT);
            b[i] = tx_line;
        end
        wait_neg(BIT);
        if (tx_line != 1'b1) ok = 0;
        t_stop = cyc;
    endtask

    task automatic expect_quiet(input int n, output bit quiet);
        quiet = 1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tx_line == 1'b0) quiet = 0;
        end
    endtask

    function automatic int exp_reply(input logic [7:0] op, input logic [15:0] d,
                                     input logic [7:0] t,
                                     output logic [7:0] b0, output logic [7:0] b1);
        b0 = '0;
        b1 = '0;
        if (op == 8'h55) begin
            b0 = d[15:8];
            b1 = d[7:0];
            return 2;
        end
        if (op == 8'h50) begin
            b0 = t;
            return 1;
        end
        return 0;
    endfunction

    // issue one command and check the whole reply
    task automatic run_cmd(input logic [7:0] op, input string req);
        logic [7:0] e0, e1, g0, g1;
        bit ok0, ok1, quiet;
        int n, s0, ts0, tp0, ts1, tp1;
        n  = exp_reply(op, dist_in, temp_in, e0, e1);
        s0 = seen_cnt;
        ok0 = 1; ok1 = 1; quiet = 1;
        g0 = '0; g1 = '0;
        fork
            send_byte(op, 1'b0);
            begin
                if (n >= 1) get_byte(g0, ok0, ts0, tp0);
                if (n == 2) get_byte(g1, ok1, ts1, tp1);
                expect_quiet(n == 0 ? QUIET : 4 * BIT, quiet);
            end
        join
        if (n >= 1) check(ok0 && g0 == e0, req, "first reply byte", g0, e0);
        if (n == 2) check(ok1 && g1 == e1, req, "second reply byte", g1, e1);
        check(quiet, req, "no extra frame", 0, 1);
        check(seen_cnt - s0 == (n > 0 ? 1 : 0), "R6", "cmd_seen pulses",
              seen_cnt - s0, (n > 0 ? 1 : 0));
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] g0, g1;
        bit ok0, ok1, quiet;
        int ts0, tp0, ts1, tp1, s0;
        logic [7:0] op;

        void'($urandom(32'd2024));
        wait_neg(5);
        // R10: reset state
        check(tx_line == 1'b1, "R10", "tx_line idle", tx_line, 1);
        check(busy == 1'b0, "R10", "busy low", busy, 0);
        check(cmd_seen == 1'b0, "R10", "cmd_seen low", cmd_seen, 0);
        rst_n = 1'b1;
        wait_neg(4 * BIT);

        // R1 / R4: directed distance corners
        dist_in = 16'hA53C; temp_in = 8'h11;
        run_cmd(8'h55, "R1");
        dist_in = 16'h0000;
        run_cmd(8'h55, "R1");
        dist_in = 16'hFFFF;
        run_cmd(8'h55, "R4");
        // R2: temperature corners
        temp_in = 8'h00;
        run_cmd(8'h50, "R2");
        temp_in = 8'hFF;
        run_cmd(8'h50, "R2");
        temp_in = 8'h81;
        run_cmd(8'h50, "R4");
        // R3: neighbouring and arbitrary codes ignored
        run_cmd(8'h54, "R3");
        run_cmd(8'h56, "R3");
        run_cmd(8'hAA, "R3");

        // R5: bad stop bit discards an otherwise valid opcode
        s0 = seen_cnt;
        fork
            send_byte(8'h55, 1'b1);
            expect_quiet(QUIET, quiet);
        join
        check(quiet, "R5", "no reply after bad stop", 0, 1);
        check(seen_cnt == s0, "R5", "no cmd_seen after bad stop", seen_cnt - s0, 0);

        // R7 / R8 / R9: capture, busy, gap, dropped command
        dist_in = 16'h1234;
        s0 = seen_cnt;
        fork
            begin
                send_byte(8'h55, 1'b0);
                send_byte(8'h50, 1'b0);
            end
            begin
                while (cmd_seen !== 1'b1) @(negedge clk);
                dist_in = 16'hBEEF;
            end
            begin
                get_byte(g0, ok0, ts0, tp0);
                check(busy == 1'b1, "R8", "busy mid reply", busy, 1);
                get_byte(g1, ok1, ts1, tp1);
                wait_neg(BIT);
                check(busy == 1'b0, "R8", "busy after reply", busy, 0);
                expect_quiet(QUIET, quiet);
            end
        join
        check(ok0 && g0 == 8'h12, "R7", "captured high byte", g0, 8'h12);
        check(ok1 && g1 == 8'h34, "R7", "captured low byte", g1, 8'h34);
        check(ts1 - tp0 >= GAP, "R9", "inter-frame gap", ts1 - tp0, GAP);
        check(quiet, "R8", "command during busy dropped", 0, 1);
        check(seen_cnt - s0 == 1, "R8", "one acceptance only", seen_cnt - s0, 1);

        // random mix
        for (int k = 0; k < 30; k++) begin
            int pick;
            pick = $urandom_range(0, 3);
            dist_in = 16'($urandom);
            temp_in = 8'($urandom);
            op = (pick == 0) ? 8'h55 : (pick == 1) ? 8'h50 : 8'($urandom);
            run_cmd(op, op == 8'h55 ? "R1" : op == 8'h50 ? "R2" : "R3");
        end

        check(seen_long == 0, "R6", "cmd_seen width", seen_long, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule